// File: doc/BRIEF.md
# Rotate and Wraparound Mask Unit

This block rotates a source word left by a variable amount and then selects bits from it with a contiguous mask. The mask is described by two bit indices, a begin index and an end index. The block counts bits from the most significant end, so index 0 is the leftmost bit. When the begin index is past the end index, the run of ones wraps around the ends of the word and leaves a hole of zeros in the middle. There are two merge modes. AND mode keeps only the rotated bits under the mask. Insert mode fills the bits outside the mask from a destination word.

The datapath is combinational: a log-depth rotator, a mask generator and a merge stage. The result and the generated mask are captured in one output register stage with a synchronous active-high reset. The mask generator is a module of its own and can be instantiated without the rotator. Its output also appears on a separate port, so the mask can be used by itself.

Top module: `rotmask_unit`

## Requirements
- R1: Bit index k of the begin and end indices names `result_o[W-1-k]` and `mask_o[W-1-k]`, so index 0 is the most significant bit.
- R2: When begin <= end, mask bits begin through end inclusive are one and all other bits are zero; begin == end yields exactly one set bit.
- R3: When begin equals end+1, the mask is all ones. This is computed one bit wider than the index, so end = 31 gives end+1 = 32, and begin = 0 with end = 31 is an ordinary full run.
- R4: When begin > end+1, mask bits end+1 through begin-1 are zero and all other bits are one; both the leftmost and rightmost mask bits are then set.
- R5: The source is rotated left circularly by `sh_i` positions: bits leaving the most significant end re-enter at the least significant end, and `sh_i` = 0 passes the source through unchanged.
- R6: With `mode_i` = 0 (AND mode), the result is the rotated source ANDed with the mask, so no result bit is set outside the mask.
- R7: With `mode_i` = 1 (insert mode), each result bit takes the rotated source where the mask is one and `dst_i` where the mask is zero.
- R8: `result_o` and `mask_o` appear one clock after their inputs. A clock edge with `rst` high clears both to zero.
- R9: `mask_o` depends only on the begin and end indices; the source, shift, destination and mode have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | W | Source word to rotate |
| sh_i | input | log2(W) | Left rotate amount |
| mb_i | input | log2(W) | Mask begin index (0 = most significant bit) |
| me_i | input | log2(W) | Mask end index (0 = most significant bit) |
| dst_i | input | W | Destination word merged in insert mode |
| mode_i | input | 1 | 0 = AND with mask, 1 = insert into destination |
| result_o | output | W | Registered rotated and masked result |
| mask_o | output | W | Registered mask |

## Verification
Rotation and the wrapped mask act in the same cycle. The rotate can carry source bits across the word boundary while the mask also wraps across it. A wrong bit order in either path then shows up only in bits near the two ends. The bench applies all 1024 begin/end pairs, each with a random source, rotate amount, destination and mode. It compares both the mask and the result against a bit-by-bit reference that applies the three begin/end rules and a modular rotate. Directed vectors then set up the two wrap cases on purpose: a single top bit rotated to the bottom under a wrapped mask, and insert mode with a wrapped mask. For these the expected word was worked out by hand.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;

    localparam int WORD_W = 32;
    localparam int IDX_W  = $clog2(WORD_W);

    typedef enum logic {
        MODE_AND    = 1'b0,
        MODE_INSERT = 1'b1
    } merge_mode_e;

    typedef enum logic [1:0] {
        SHAPE_RUN  = 2'd0,
        SHAPE_FULL = 2'd1,
        SHAPE_WRAP = 2'd2
    } mask_shape_e;

    // Decide the mask shape from the begin index and the end index plus one,
    // both held one bit wider than the index so end+1 never wraps.
    function automatic mask_shape_e classify_shape(input int begin_x, input int end_p1);
        if (begin_x < end_p1)
            return SHAPE_RUN;
        else if (begin_x == end_p1)
            return SHAPE_FULL;
        else
            return SHAPE_WRAP;
    endfunction

    function automatic logic [WORD_W-1:0] merge_bits(
        input logic [WORD_W-1:0] rot,
        input logic [WORD_W-1:0] msk,
        input logic [WORD_W-1:0] dst,
        input merge_mode_e       mode
    );
        if (mode == MODE_INSERT)
            return (rot & msk) | (dst & ~msk);
        return rot & msk;
    endfunction

endpackage

// File: rtl/rm_rotator.sv
module rm_rotator #(
    parameter int W  = rotmask_pkg::WORD_W,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  data_i,
    input  logic [IW-1:0] amt_i,
    output logic [W-1:0]  data_o
);

    logic [W-1:0] stage [0:IW];

    assign stage[0] = data_i;

    // Log-depth barrel: stage s rotates left by 2**s when amt_i[s] is set.
    for (genvar s = 0; s < IW; s++) begin : g_stage
        localparam int STEP = 1 << s;
        assign stage[s+1] = amt_i[s]
            ? {stage[s][W-1-STEP:0], stage[s][W-1 -: STEP]}
            : stage[s];
    end

    assign data_o = stage[IW];

endmodule

// File: rtl/rm_mask_gen.sv
module rm_mask_gen #(
    parameter int W  = rotmask_pkg::WORD_W,
    parameter int IW = $clog2(W)
) (
    input  logic [IW-1:0] begin_i,
    input  logic [IW-1:0] end_i,
    output logic [W-1:0]  mask_o
);
    import rotmask_pkg::*;

    logic [IW:0]  begin_x;
    logic [IW:0]  end_p1;
    mask_shape_e  shape;

    assign begin_x = {1'b0, begin_i};
    assign end_p1  = {1'b0, end_i} + {{IW{1'b0}}, 1'b1};

    always_comb shape = classify_shape(int'(begin_x), int'(end_p1));

    // Position k counts from the most significant bit.
    for (genvar k = 0; k < W; k++) begin : g_bit
        localparam logic [IW:0] POS = (IW+1)'(k);
        logic in_run;
        logic in_hole;
        assign in_run  = (POS >= begin_x) && (POS < end_p1);
        assign in_hole = (POS >= end_p1)  && (POS < begin_x);
        assign mask_o[W-1-k] = (shape == SHAPE_FULL) ? 1'b1 :
                               (shape == SHAPE_RUN)  ? in_run : !in_hole;
    end

endmodule

// File: rtl/rm_merge.sv
module rm_merge #(
    parameter int W = rotmask_pkg::WORD_W
) (
    input  logic [W-1:0]             rot_i,
    input  logic [W-1:0]             mask_i,
    input  logic [W-1:0]             dst_i,
    input  rotmask_pkg::merge_mode_e mode_i,
    output logic [W-1:0]             res_o
);
    import rotmask_pkg::*;

    logic [W-1:0] kept;
    logic [W-1:0] filled;

    assign kept   = rot_i & mask_i;
    assign filled = dst_i & ~mask_i;

    always_comb begin
        unique case (mode_i)
            MODE_INSERT: res_o = kept | filled;
            default:     res_o = kept;
        endcase
    end

endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit #(
    parameter int W  = rotmask_pkg::WORD_W,
    parameter int IW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  src_i,
    input  logic [IW-1:0] sh_i,
    input  logic [IW-1:0] mb_i,
    input  logic [IW-1:0] me_i,
    input  logic [W-1:0]  dst_i,
    input  logic          mode_i,
    output logic [W-1:0]  result_o,
    output logic [W-1:0]  mask_o
);
    import rotmask_pkg::*;

    merge_mode_e  mode;
    logic [W-1:0] rotated;
    logic [W-1:0] mask_c;
    logic [W-1:0] merged;

    assign mode = merge_mode_e'(mode_i);

    rm_rotator #(.W(W), .IW(IW)) u_rot (
        .data_i (src_i),
        .amt_i  (sh_i),
        .data_o (rotated)
    );

    rm_mask_gen #(.W(W), .IW(IW)) u_mask (
        .begin_i (mb_i),
        .end_i   (me_i),
        .mask_o  (mask_c)
    );

    rm_merge #(.W(W)) u_merge (
        .rot_i  (rotated),
        .mask_i (mask_c),
        .dst_i  (dst_i),
        .mode_i (mode),
        .res_o  (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o <= '0;
            mask_o   <= '0;
        end else begin
            result_o <= merged;
            mask_o   <= mask_c;
        end
    end

endmodule

// File: rtl/rotmask_unit_chk.sv
module rotmask_unit_chk #(
    parameter int W  = rotmask_pkg::WORD_W,
    parameter int IW = $clog2(W)
) (
    input logic          clk,
    input logic          rst,
    input logic [W-1:0]  src_i,
    input logic [IW-1:0] sh_i,
    input logic [IW-1:0] mb_i,
    input logic [IW-1:0] me_i,
    input logic [W-1:0]  dst_i,
    input logic          mode_i,
    input logic [W-1:0]  result_o,
    input logic [W-1:0]  mask_o
);

    assert_reset_clear_R8: assert property (@(posedge clk)
        rst |=> (result_o == '0 && mask_o == '0));

    assert_and_inside_mask_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(mode_i)) |-> ((result_o & ~mask_o) == '0));

    assert_insert_outside_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode_i)) |-> ((result_o & ~mask_o) == ($past(dst_i) & ~mask_o)));

    assert_single_bit_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mb_i) == $past(me_i)) |-> ($countones(mask_o) == 1));

    assert_full_mask_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ({1'b0, $past(mb_i)} == {1'b0, $past(me_i)} + {{IW{1'b0}}, 1'b1}))
        |-> (mask_o == '1));

    assert_wrap_ends_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ({1'b0, $past(mb_i)} > {1'b0, $past(me_i)} + {{IW{1'b0}}, 1'b1}))
        |-> (mask_o[W-1] && mask_o[0]));

    assert_passthru_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(sh_i) == '0 && !$past(mode_i) && mask_o == '1)
        |-> (result_o == $past(src_i)));

endmodule

bind rotmask_unit rotmask_unit_chk #(.W(W), .IW(IW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .src_i    (src_i),
    .sh_i     (sh_i),
    .mb_i     (mb_i),
    .me_i     (me_i),
    .dst_i    (dst_i),
    .mode_i   (mode_i),
    .result_o (result_o),
    .mask_o   (mask_o)
);

// File: tb/rotmask_unit_tb.sv
module rotmask_unit_tb;

    localparam int W        = 32;
    localparam int IW       = 5;
    localparam int CLK_HALF = 5;
    localparam int CLK_PER  = 2 * CLK_HALF;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  src_i = '0;
    logic [IW-1:0] sh_i = '0;
    logic [IW-1:0] mb_i = '0;
    logic [IW-1:0] me_i = '0;
    logic [W-1:0]  dst_i = '0;
    logic          mode_i = 1'b0;
    logic [W-1:0]  result_o;
    logic [W-1:0]  mask_o;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_HALF) clk = ~clk;

    rotmask_unit #(.W(W), .IW(IW)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .src_i    (src_i),
        .sh_i     (sh_i),
        .mb_i     (mb_i),
        .me_i     (me_i),
        .dst_i    (dst_i),
        .mode_i   (mode_i),
        .result_o (result_o),
        .mask_o   (mask_o)
    );

    // Reference mask: index i counts from the most significant bit.
    function automatic logic [W-1:0] ref_mask(input int b, input int e);
        logic [W-1:0] m;
        for (int i = 0; i < W; i++) begin
            bit on;
            if (b < e + 1)       on = (i >= b) && (i <= e);
            else if (b == e + 1) on = 1'b1;
            else                 on = !((i >= e + 1) && (i <= b - 1));
            m[W-1-i] = on;
        end
        return m;
    endfunction

    function automatic logic [W-1:0] ref_rotl(input logic [W-1:0] x, input int s);
        logic [W-1:0] r;
        for (int k = 0; k < W; k++) r[(k + s) % W] = x[k];
        return r;
    endfunction

    function automatic string mask_req(input int b, input int e);
        if (b < e + 1)  return "R2";
        if (b == e + 1) return "R3";
        return "R4";
    endfunction

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, exp);
        end
    endtask

    // Drive one vector, let one clock capture it, sample after the edge.
    task automatic run_vec(input logic [W-1:0] s, input int sh, input int b, input int e,
                           input logic [W-1:0] d, input bit md,
                           input string mreq, input string rreq);
        logic [W-1:0] em;
        logic [W-1:0] er;
        src_i = s; sh_i = IW'(sh); mb_i = IW'(b); me_i = IW'(e); dst_i = d; mode_i = md;
        em = ref_mask(b, e);
        er = md ? ((ref_rotl(s, sh) & em) | (d & ~em)) : (ref_rotl(s, sh) & em);
        @(posedge clk);
        #1;
        check(mreq, "mask", mask_o, em);
        check(rreq, "result", result_o, er);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        // R8: reset clears both outputs even with live inputs.
        src_i = 32'hDEAD_BEEF; mb_i = 5'd3; me_i = 5'd9; mode_i = 1'b1; dst_i = '1;
        repeat (3) @(posedge clk);
        #1;
        check("R8", "reset result", result_o, '0);
        check("R8", "reset mask", mask_o, '0);
        rst = 1'b0;

        // R1: begin = end = 0 selects the most significant bit only.
        run_vec(32'hFFFF_FFFF, 0, 0, 0, '0, 1'b0, "R1", "R1");
        run_vec(32'hFFFF_FFFF, 0, 31, 31, '0, 1'b0, "R1", "R1");
        // R3: end = 31 with begin 0 is a full run; begin = end+1 is full.
        run_vec(32'h1234_5678, 0, 0, 31, '0, 1'b0, "R3", "R5");
        run_vec(32'h1234_5678, 0, 9, 8, '0, 1'b0, "R3", "R5");
        // R5: circular rotate carries the top bit to the bottom.
        run_vec(32'h8000_0001, 1, 0, 31, '0, 1'b0, "R3", "R5");
        run_vec(32'hF000_000F, 4, 0, 31, '0, 1'b0, "R3", "R5");
        // R4: wrapped mask with a hole, AND and insert.
        run_vec(32'h8000_0000, 1, 28, 3, 32'hAAAA_AAAA, 1'b0, "R4", "R6");
        check("R4", "hand mask 28..3", mask_o, 32'hF000_000F);
        check("R6", "hand and", result_o, 32'h0000_0001);
        run_vec(32'h8000_0000, 1, 28, 3, 32'hAAAA_AAAA, 1'b1, "R4", "R7");
        check("R7", "hand insert", result_o, 32'h0AAA_AAA1);
        // R7: insert with a plain run.
        run_vec(32'h0000_00FF, 8, 16, 23, 32'h1234_5678, 1'b1, "R2", "R7");
        check("R7", "hand insert run", result_o, 32'h1234_FF78);

        // R9: mask unaffected by source, shift, destination and mode.
        run_vec(32'h0, 0, 5, 20, 32'h0, 1'b0, "R9", "R6");
        run_vec(32'hFFFF_FFFF, 17, 5, 20, 32'hFFFF_FFFF, 1'b1, "R9", "R7");

        // Sweep every begin/end pair with random data.
        for (int b = 0; b < W; b++) begin
            for (int e = 0; e < W; e++) begin
                logic [W-1:0] s;
                logic [W-1:0] d;
                int sh;
                bit md;
                s  = $urandom;
                d  = $urandom;
                sh = $urandom_range(W-1, 0);
                md = 1'($urandom_range(1, 0));
                run_vec(s, sh, b, e, d, md, mask_req(b, e), md ? "R7" : "R6");
            end
        end

        // R8: reset asserted mid-run clears the registers again.
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R8", "late reset result", result_o, '0);
        check("R8", "late reset mask", mask_o, '0);
        rst = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule